// File: doc/BRIEF.md
# Flash Toggle-Bit Polling Controller

This block sits on the host side of an external parallel flash device. It decides whether an embedded program or erase inside the device has finished. After a start request it issues status read cycles. It compares bit 6 of each pair of consecutive status bytes and looks at bit 5, the error flag that the device raises when its internal time limit is exceeded. It then reports completion, failure, or that it is still working.

When the outcome is a failure, the controller writes the reset command to the device so that the device returns to array-read mode, and only then reports the failure. A poll budget, set by a parameter, turns an operation that never settles into a time-out failure. An abort input drops the current poll at once. The bus side is a plain request/acknowledge pair for reads and another for writes. Bus timing is generated elsewhere.

When bit 5 is high and bit 6 is still toggling, the controller does not declare failure straight away. It first reads one more pair. Toggling may have stopped in the same instant that the error flag rose, and only a fresh pair can show which case applies.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: After reset, busy_o, rd_req_o, wr_req_o, done_o, fail_o, timeout_o and erase_sect_o are all 0.
- R2: When start_i is seen while idle, rd_req_o rises in the next cycle. Each read request is held high until a cycle in which rd_ack_i is 1, and rd_data_i is captured in that cycle.
- R3: If bit 6 of the second byte of a pair equals bit 6 of the first byte, done_o is 1 for exactly one cycle, in the cycle after the second acknowledge. No write is issued and the block returns to idle.
- R4: If bit 6 differs and bit 5 of the second byte is 0, and the poll budget is not used up, the block stays busy and starts a new read pair in the next cycle.
- R5: If bit 6 differs and bit 5 of the second byte is 1, the block reads one more pair. If bit 6 is equal within that pair, done_o pulses as in R3.
- R6: If bit 6 still differs in the recheck pair, wr_req_o rises with wr_data_o = 0xF0 and is held until wr_ack_i is 1. In the cycle after that acknowledge, fail_o is 1 for one cycle with timeout_o = 0, and the block goes idle.
- R7: If MAX_POLLS consecutive pairs each toggle with bit 5 = 0, the reset write of R6 is issued after the last of those pairs. After its acknowledge, fail_o and timeout_o pulse together for one cycle.
- R8: When abort_i is 1 while busy, the next cycle shows busy_o = 0, both requests low and no done_o or fail_o. This holds even if an acknowledge arrives in the same cycle. The next start begins again with a full first read pair.
- R9: After each completed pair, erase_sect_o shows whether bit 2 differed between the two bytes of that pair, and it keeps that value until the next pair completes.
- R10: done_o and fail_o are never 1 together, and rd_req_o and wr_req_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted when idle) |
| abort_i | input | 1 | Abandon polling, return to idle |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read completed, data valid |
| rd_data_i | input | 8 | Status byte returned by the device |
| wr_req_o | output | 1 | Reset-command write request |
| wr_data_o | output | 8 | Write data (reset command 0xF0) |
| wr_ack_i | input | 1 | Write completed |
| busy_o | output | 1 | Polling or resetting in progress |
| done_o | output | 1 | One-cycle pulse: operation finished |
| fail_o | output | 1 | One-cycle pulse: operation failed |
| timeout_o | output | 1 | Set with fail_o when the poll budget caused the failure |
| erase_sect_o | output | 1 | Bit 2 toggled in the last completed pair |

## Verification
An abort and a bus acknowledge can arrive in the same cycle. An acknowledge on the second read of a settled pair would otherwise finish the poll with done_o. The bench drives abort_i and rd_ack_i in the same cycle, with data that would end in success. It then requires no done_o pulse, an idle block, and a restart that takes two fresh reads before done_o. The same collision is also set up on the first read of a pair, where the acknowledge would otherwise have stored a byte.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;

    localparam int TGL_BIT  = 6;
    localparam int ERR_BIT  = 5;
    localparam int SECT_BIT = 2;
    localparam logic [7:0] RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_RC1,
        ST_RC2,
        ST_RST
    } poll_st_e;

    typedef struct packed {
        poll_st_e   st;
        logic [7:0] first;
        logic       done;
        logic       fail;
        logic       tmo;
        logic       erase;
        logic       tmo_pend;
    } poll_regs_t;

endpackage

// File: rtl/tgl_pair_cmp.sv
module tgl_pair_cmp
    import tgl_poll_pkg::*;
#(
    parameter bit ERASE_DETECT = 1'b1
) (
    input  logic [7:0] first_i,
    input  logic [7:0] second_i,
    output logic       toggled_o,
    output logic       err_o,
    output logic       erase_tgl_o
);
    assign toggled_o = first_i[TGL_BIT] ^ second_i[TGL_BIT];
    assign err_o     = second_i[ERR_BIT];

    generate
        if (ERASE_DETECT) begin : g_sect
            assign erase_tgl_o = first_i[SECT_BIT] ^ second_i[SECT_BIT];
        end else begin : g_nosect
            assign erase_tgl_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/poll_limit_cnt.sv
module poll_limit_cnt #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != LAST_VAL) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
    import tgl_poll_pkg::*;
#(
    parameter int MAX_POLLS    = 8,
    parameter bit ERASE_DETECT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       abort_i,
    output logic       rd_req_o,
    input  logic       rd_ack_i,
    input  logic [7:0] rd_data_i,
    output logic       wr_req_o,
    output logic [7:0] wr_data_o,
    input  logic       wr_ack_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       fail_o,
    output logic       timeout_o,
    output logic       erase_sect_o
);
    poll_regs_t r_d, r_q;

    logic cmp_tgl, cmp_err, cmp_erase;
    logic cnt_clr, cnt_inc, cnt_last;

    tgl_pair_cmp #(.ERASE_DETECT(ERASE_DETECT)) u_cmp (
        .first_i     (r_q.first),
        .second_i    (rd_data_i),
        .toggled_o   (cmp_tgl),
        .err_o       (cmp_err),
        .erase_tgl_o (cmp_erase)
    );

    poll_limit_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (cnt_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        r_d.tmo  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;

        if (abort_i) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        r_d.st       = ST_RD1;
                        r_d.tmo_pend = 1'b0;
                        cnt_clr      = 1'b1;
                    end
                end
                ST_RD1: begin
                    if (rd_ack_i) begin
                        r_d.first = rd_data_i;
                        r_d.st    = ST_RD2;
                    end
                end
                ST_RC1: begin
                    if (rd_ack_i) begin
                        r_d.first = rd_data_i;
                        r_d.st    = ST_RC2;
                    end
                end
                ST_RD2: begin
                    if (rd_ack_i) begin
                        r_d.erase = cmp_erase;
                        if (!cmp_tgl) begin
                            r_d.done = 1'b1;
                            r_d.st   = ST_IDLE;
                        end else if (cmp_err) begin
                            r_d.st = ST_RC1;
                        end else if (cnt_last) begin
                            r_d.st       = ST_RST;
                            r_d.tmo_pend = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                            r_d.st  = ST_RD1;
                        end
                    end
                end
                ST_RC2: begin
                    if (rd_ack_i) begin
                        r_d.erase = cmp_erase;
                        if (!cmp_tgl) begin
                            r_d.done = 1'b1;
                            r_d.st   = ST_IDLE;
                        end else begin
                            r_d.st       = ST_RST;
                            r_d.tmo_pend = 1'b0;
                        end
                    end
                end
                ST_RST: begin
                    if (wr_ack_i) begin
                        r_d.fail = 1'b1;
                        r_d.tmo  = r_q.tmo_pend;
                        r_d.st   = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, first: 8'h00, done: 1'b0, fail: 1'b0,
                     tmo: 1'b0, erase: 1'b0, tmo_pend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o     = (r_q.st == ST_RD1) || (r_q.st == ST_RD2) ||
                          (r_q.st == ST_RC1) || (r_q.st == ST_RC2);
    assign wr_req_o     = (r_q.st == ST_RST);
    assign wr_data_o    = RESET_CMD;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign fail_o       = r_q.fail;
    assign timeout_o    = r_q.tmo;
    assign erase_sect_o = r_q.erase;
endmodule

module tgl_poll_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic abort_i,
    input logic rd_req_o,
    input logic wr_req_o,
    input logic wr_ack_i,
    input logic busy_o,
    input logic done_o,
    input logic fail_o,
    input logic timeout_o
);
    AST_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !abort_i) |=> rd_req_o); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> $past(wr_req_o && wr_ack_i)); // R6

    AST_TMO_WITH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> fail_o); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o && !fail_o && !rd_req_o && !wr_req_o)); // R8

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o)); // R10

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o)); // R10
endmodule

bind tgl_poll_ctrl tgl_poll_chk u_chk (.*);

// File: tb/tb_tgl_poll_ctrl.sv
`timescale 1ns/1ps
module tb_tgl_poll_ctrl;
    localparam int MAXP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, abort_i = 1'b0;
    logic       rd_ack_i = 1'b0, wr_ack_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       rd_req_o, wr_req_o, busy_o, done_o, fail_o, timeout_o, erase_sect_o;
    logic [7:0] wr_data_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tgl_poll_ctrl #(.MAX_POLLS(MAXP), .ERASE_DETECT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .timeout_o(timeout_o), .erase_sect_o(erase_sect_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic serve_rd(input logic [7:0] d);
        while (!rd_req_o) @(negedge clk);
        rd_ack_i  = 1'b1;
        rd_data_i = d;
        @(negedge clk);
        rd_ack_i  = 1'b0;
    endtask

    task automatic serve_wr();
        while (!wr_req_o) @(negedge clk);
        wr_ack_i = 1'b1;
        @(negedge clk);
        wr_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", busy_o, 0);
        chk_eq("R1 rd_req", rd_req_o, 0);
        chk_eq("R1 wr_req", wr_req_o, 0);
        chk_eq("R1 done/fail/tmo", {done_o, fail_o, timeout_o}, 0);
        chk_eq("R1 erase", erase_sect_o, 0);
    endtask

    task automatic t_quick_done();
        do_start();
        chk_eq("R2 rd_req after start", rd_req_o, 1);
        repeat (2) @(negedge clk);
        chk_eq("R2 rd_req held", rd_req_o, 1);
        serve_rd(8'h40);
        serve_rd(8'h40);
        chk_eq("R3 done pulse", done_o, 1);
        chk_eq("R10 no fail with done", fail_o, 0);
        chk_eq("R3 no write", wr_req_o, 0);
        chk_eq("R3 idle", busy_o, 0);
        @(negedge clk);
        chk_eq("R3 done one cycle", done_o, 0);
    endtask

    task automatic t_continue();
        do_start();
        serve_rd(8'h00);
        serve_rd(8'h40);
        chk_eq("R4 still busy", busy_o, 1);
        chk_eq("R4 new read", rd_req_o, 1);
        chk_eq("R4 no result", {done_o, fail_o}, 0);
        serve_rd(8'h40);
        serve_rd(8'h40);
        chk_eq("R4 done after settle", done_o, 1);
    endtask

    task automatic t_recheck_ok();
        do_start();
        serve_rd(8'h00);
        serve_rd(8'h60);
        chk_eq("R5 recheck read", rd_req_o, 1);
        chk_eq("R5 no early fail", {fail_o, wr_req_o}, 0);
        serve_rd(8'h60);
        serve_rd(8'h60);
        chk_eq("R5 done on recheck", done_o, 1);
        chk_eq("R5 no write", wr_req_o, 0);
    endtask

    task automatic t_recheck_fail();
        do_start();
        serve_rd(8'h00);
        serve_rd(8'h60);
        serve_rd(8'h20);
        serve_rd(8'h60);
        chk_eq("R6 write req", wr_req_o, 1);
        chk_eq("R6 write data", wr_data_o, 8'hF0);
        chk_eq("R10 no read during write", rd_req_o, 0);
        repeat (2) @(negedge clk);
        chk_eq("R6 write held", wr_req_o, 1);
        chk_eq("R6 no fail before ack", fail_o, 0);
        serve_wr();
        chk_eq("R6 fail pulse", fail_o, 1);
        chk_eq("R6 no timeout", timeout_o, 0);
        chk_eq("R10 no done with fail", done_o, 0);
        @(negedge clk);
        chk_eq("R6 fail one cycle", fail_o, 0);
        chk_eq("R6 idle", busy_o, 0);
    endtask

    task automatic t_timeout();
        do_start();
        for (int i = 0; i < MAXP - 1; i++) begin
            serve_rd(8'h00);
            serve_rd(8'h40);
        end
        chk_eq("R7 no write before limit", wr_req_o, 0);
        serve_rd(8'h00);
        serve_rd(8'h40);
        chk_eq("R7 write at limit", wr_req_o, 1);
        serve_wr();
        chk_eq("R7 fail", fail_o, 1);
        chk_eq("R7 timeout", timeout_o, 1);
    endtask

    task automatic t_abort();
        do_start();
        serve_rd(8'h40);
        while (!rd_req_o) @(negedge clk);
        abort_i   = 1'b1;
        rd_ack_i  = 1'b1;
        rd_data_i = 8'h40;
        @(negedge clk);
        abort_i  = 1'b0;
        rd_ack_i = 1'b0;
        chk_eq("R8 idle after abort", busy_o, 0);
        chk_eq("R8 no done on abort+ack", done_o, 0);
        chk_eq("R8 requests dropped", {rd_req_o, wr_req_o}, 0);
        do_start();
        serve_rd(8'h00);
        chk_eq("R8 restart needs first pair", done_o, 0);
        chk_eq("R8 second read requested", rd_req_o, 1);
        serve_rd(8'h00);
        chk_eq("R8 done after fresh pair", done_o, 1);
        do_start();
        while (!rd_req_o) @(negedge clk);
        abort_i   = 1'b1;
        rd_ack_i  = 1'b1;
        rd_data_i = 8'h40;
        @(negedge clk);
        abort_i  = 1'b0;
        rd_ack_i = 1'b0;
        chk_eq("R8 idle after first-read abort", busy_o, 0);
        do_start();
        serve_rd(8'h00);
        chk_eq("R8 first-read abort stored nothing", done_o, 0);
        serve_rd(8'h00);
        chk_eq("R8 done after first-read abort", done_o, 1);
    endtask

    task automatic t_erase();
        do_start();
        serve_rd(8'h04);
        serve_rd(8'h00);
        chk_eq("R9 erase toggled", erase_sect_o, 1);
        repeat (3) @(negedge clk);
        chk_eq("R9 erase held", erase_sect_o, 1);
        do_start();
        serve_rd(8'h04);
        serve_rd(8'h04);
        chk_eq("R9 erase steady", erase_sect_o, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (R1..) actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quick_done();
        t_continue();
        t_recheck_ok();
        t_recheck_fail();
        t_timeout();
        t_abort();
        t_erase();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule